// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a virtual address into a physical address by walking page tables held in memory. It handles three paged formats: a 32-bit format with two levels and 4-byte entries, a 39-bit format with three levels, and a 48-bit format with four levels, both with 8-byte entries. The format and the root table page number are taken from the translation control value at the moment a request is accepted. The walk then reads one table entry at a time and checks each entry for validity and for a leaf. When it finds a leaf, it builds the physical address, including the superpage case where low virtual page fields pass through unchanged.

A client offers a virtual address on a valid/ready request port. `req_ready` is high only while the walker is idle, so a new request is held off for the whole length of a walk. The answer is a single-cycle pulse on `resp_valid` that carries the physical address and a fault flag. The response port has no ready signal, so the client must be able to take the answer in the cycle it appears. On the memory side, `mem_req_valid` and `mem_addr` stay unchanged until `mem_req_ready` is seen, and only one read is in flight at any time. The read data is taken in the cycle `mem_rsp_valid` is high. When translation is disabled, or the mode is off, the address passes straight through.

Top module: `ptw_walker`

## Requirements
- R1: `ctl_mode` selects the format: 1 is the 32-bit format (2 levels, 4-byte entries), 8 is the 39-bit format (3 levels, 8-byte entries) and 9 is the 48-bit format (4 levels, 8-byte entries). Any other nonzero code with `xlat_en` high gives a fault response one cycle after acceptance, and no memory read is made.
- R2: The first table is at `ctl_root_ppn << 12`, and the walk starts at the top level. The entry address at level L is the table address plus VPN[L] times the entry size. VPN[L] is 10 bits at virtual bit 12+10L in the 32-bit format, and 9 bits at virtual bit 12+9L in the other formats.
- R3: An entry is checked as follows, with bit 0 = valid, bit 1 = read, bit 2 = write and bit 3 = execute. If valid is clear, or write is set while read is clear, the walk stops and the response has `resp_fault`=1 and `resp_paddr`=0.
- R4: An entry with read or execute set is a leaf and ends the walk. Otherwise the next table address is (entry >> 10) << 12, and the walk moves down one level.
- R5: A valid non-leaf entry found at level 0 gives a fault response.
- R6: The physical address starts from the virtual address. For every level from the leaf level up to the top level, the entry field is copied into the address. Entry fields start at entry bit 10+9L and address fields at bit 12+9L. In the 32-bit format they start at entry bits 10 and 20 and address bits 12 and 22. Every field has the VPN width, except the top one, which is 12, 26 or 17 bits wide in the 32-, 39- and 48-bit formats.
- R7: With `xlat_en` low, or `ctl_mode`=0, `resp_paddr` equals the request address and `resp_fault`=0. No memory read is made, and `resp_valid` pulses in the cycle after acceptance.
- R8: In the 32-bit format, only bits 31:0 of `mem_rsp_data` form the entry. The upper 32 bits have no effect.
- R9: `mem_req_valid` stays high with a stable `mem_addr` until `mem_req_ready` is seen. After a handshake, no new read is requested until the response has arrived.
- R10: `req_ready` is high only when idle and drops after acceptance. `resp_valid` is a one-cycle pulse, and the walker is ready again in the following cycle.
- R11: A walk that ends at a leaf on level L of an N-level format makes exactly N-L memory reads. A walk that faults on an entry at level L makes N-L reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable; low means pass-through |
| ctl_mode | input | 4 | Translation format code |
| ctl_root_ppn | input | PPN_W (44) | Root table page number |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | ADDR_W (64) | Virtual address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | ADDR_W (64) | Physical address (0 on fault) |
| resp_fault | output | 1 | Translation fault |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | ADDR_W (64) | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W (64) | Read data |

## Verification
Most internal faults show up on `mem_addr` within a single read. A wrong level counter, table register or VPN slice sends the read to an address the bench memory does not hold, so the entry comes back as zero and the walk ends in a fault that the bench did not expect. A wrong leaf level or wrong field bounds leaves the read addresses correct but corrupts `resp_paddr` in the response cycle, which is why the sweep covers every leaf level of every format. Sequencing faults, such as an extra or a skipped level, or a lost handshake, change the number of reads counted on the memory port, or the delay until `resp_valid`.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PG_SHIFT = 12;
  localparam int PTE_PPN_LSB = 10;

  localparam logic [3:0] MODE_OFF = 4'd0;
  localparam logic [3:0] MODE_P32 = 4'd1;
  localparam logic [3:0] MODE_P39 = 4'd8;
  localparam logic [3:0] MODE_P48 = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} walk_state_e;

  function automatic int levels_of(logic [3:0] m);
    case (m)
      MODE_P32: return 2;
      MODE_P39: return 3;
      MODE_P48: return 4;
      default:  return 0;
    endcase
  endfunction

  function automatic int vpn_w(logic [3:0] m);
    return (m == MODE_P32) ? 10 : 9;
  endfunction

  function automatic int ent_shift(logic [3:0] m);
    return (m == MODE_P32) ? 2 : 3;
  endfunction

  function automatic int top_ppn_w(logic [3:0] m);
    case (m)
      MODE_P32: return 12;
      MODE_P39: return 26;
      default:  return 17;
    endcase
  endfunction

  function automatic int ppn_w(logic [3:0] m, int l);
    return (l == levels_of(m) - 1) ? top_ppn_w(m) : vpn_w(m);
  endfunction
endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] pte,
  output logic              bad,
  output logic              leaf
);
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;

  always_comb begin
    bad  = !pte[B_V] || (!pte[B_R] && pte[B_W]);
    leaf = pte[B_R] || pte[B_X];
  end
endmodule

// File: rtl/ptw_fmt.sv
module ptw_fmt
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int MAX_LVL = 4,
  localparam int LVL_W = $clog2(MAX_LVL)
) (
  input  logic [3:0]        mode,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] rsp_raw,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [DATA_W-1:0] pte,
  output logic [ADDR_W-1:0] next_tbl,
  output logic [ADDR_W-1:0] paddr
);
  logic [ADDR_W-1:0] vpn;
  logic [ADDR_W-1:0] fmask;
  logic [ADDR_W-1:0] field;
  int                w;
  int                nlev;

  always_comb begin
    nlev = levels_of(mode);
    vpn  = (vaddr >> (PG_SHIFT + int'(lvl) * vpn_w(mode))) &
           ((ADDR_W'(1) << vpn_w(mode)) - ADDR_W'(1));
    ent_addr = tbl_addr + (vpn << ent_shift(mode));

    pte = (mode == MODE_P32) ? DATA_W'(rsp_raw[31:0]) : rsp_raw;
    next_tbl = ADDR_W'(pte >> PTE_PPN_LSB) << PG_SHIFT;

    paddr = vaddr;
    w     = 0;
    fmask = '0;
    field = '0;
    for (int l = 0; l < MAX_LVL; l++) begin
      if (l >= int'(lvl) && l < nlev) begin
        w     = ppn_w(mode, l);
        fmask = (ADDR_W'(1) << w) - ADDR_W'(1);
        field = ADDR_W'(pte >> (PTE_PPN_LSB + l * vpn_w(mode))) & fmask;
        paddr = (paddr & ~(fmask << (PG_SHIFT + l * vpn_w(mode)))) |
                (field << (PG_SHIFT + l * vpn_w(mode)));
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int PPN_W = 44,
  parameter int MAX_LVL = 4,
  localparam int LVL_W = $clog2(MAX_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en,
  input  logic [3:0]        ctl_mode,
  input  logic [PPN_W-1:0]  ctl_root_ppn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              resp_valid,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic              resp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  walk_state_e       st_q;
  logic [ADDR_W-1:0] va_q, tbl_q, pa_q;
  logic [3:0]        mode_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              flt_q;

  logic [ADDR_W-1:0] ent_addr, next_tbl, comp_pa;
  logic [DATA_W-1:0] pte;
  logic              pte_bad, pte_leaf;
  logic              accept, bypass, unsup;

  ptw_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LVL(MAX_LVL)) u_fmt (
    .mode(mode_q), .lvl(lvl_q), .vaddr(va_q), .tbl_addr(tbl_q),
    .rsp_raw(mem_rsp_data), .ent_addr(ent_addr), .pte(pte),
    .next_tbl(next_tbl), .paddr(comp_pa)
  );

  ptw_pte_check #(.DATA_W(DATA_W)) u_chk (
    .pte(pte), .bad(pte_bad), .leaf(pte_leaf)
  );

  assign accept = req_valid && req_ready;
  assign bypass = !xlat_en || (ctl_mode == MODE_OFF);
  assign unsup  = levels_of(ctl_mode) == 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      va_q   <= '0;
      tbl_q  <= '0;
      pa_q   <= '0;
      mode_q <= MODE_OFF;
      lvl_q  <= '0;
      flt_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          va_q   <= req_vaddr;
          mode_q <= ctl_mode;
          if (bypass) begin
            pa_q  <= req_vaddr;
            flt_q <= 1'b0;
            st_q  <= S_DONE;
          end else if (unsup) begin
            pa_q  <= '0;
            flt_q <= 1'b1;
            st_q  <= S_DONE;
          end else begin
            tbl_q <= ADDR_W'(ctl_root_ppn) << PG_SHIFT;
            lvl_q <= LVL_W'(levels_of(ctl_mode) - 1);
            st_q  <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (pte_bad || (!pte_leaf && lvl_q == '0)) begin
            pa_q  <= '0;
            flt_q <= 1'b1;
            st_q  <= S_DONE;
          end else if (pte_leaf) begin
            pa_q  <= comp_pa;
            flt_q <= 1'b0;
            st_q  <= S_DONE;
          end else begin
            tbl_q <= next_tbl;
            lvl_q <= lvl_q - LVL_W'(1);
            st_q  <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == S_IDLE);
  assign mem_req_valid = (st_q == S_ISSUE);
  assign mem_addr      = ent_addr;
  assign resp_valid    = (st_q == S_DONE);
  assign resp_paddr    = pa_q;
  assign resp_fault    = flt_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xlat_en |=>
      resp_valid && !resp_fault && !mem_req_valid && resp_paddr == $past(req_vaddr));
  // R1
  unsup_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && xlat_en && ctl_mode != MODE_OFF && ctl_mode != MODE_P32 &&
    ctl_mode != MODE_P39 && ctl_mode != MODE_P48 |=> resp_valid && resp_fault);
  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == '0);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b0;
  logic [3:0]  ctl_mode = 4'd0;
  logic [43:0] ctl_root_ppn = 44'h80;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = 64'd0;
  logic        resp_valid;
  logic [63:0] resp_paddr;
  logic        resp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  int n_chk = 0;
  int n_err = 0;
  int rd_cnt = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] ent_at [4];

  localparam logic [43:0] ROOT = 44'h80;

  always #10 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .ctl_mode(ctl_mode),
    .ctl_root_ppn(ctl_root_ppn), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nlev(input logic [3:0] m);
    return (m == 4'd1) ? 2 : (m == 4'd8) ? 3 : (m == 4'd9) ? 4 : 0;
  endfunction
  function automatic int fw(input logic [3:0] m, input int l);
    if (l == nlev(m) - 1) return (m == 4'd1) ? 12 : (m == 4'd8) ? 26 : 17;
    return (m == 4'd1) ? 10 : 9;
  endfunction
  function automatic int step(input logic [3:0] m);
    return (m == 4'd1) ? 10 : 9;
  endfunction
  function automatic logic [63:0] vpn(input logic [3:0] m, input logic [63:0] va, input int l);
    return (va >> (12 + step(m) * l)) & ((64'd1 << step(m)) - 64'd1);
  endfunction
  function automatic logic [63:0] wrap(input logic [3:0] m, input logic [63:0] pte);
    return (m == 4'd1) ? {32'hDEADBEEF, pte[31:0]} : pte;
  endfunction
  function automatic logic [63:0] exp_pa(input logic [3:0] m, input logic [63:0] va,
                                         input logic [63:0] pte, input int leaf);
    logic [63:0] pa = va;
    for (int l = leaf; l < nlev(m); l++) begin
      logic [63:0] msk = (64'd1 << fw(m, l)) - 64'd1;
      pa = (pa & ~(msk << (12 + step(m) * l))) |
           (((pte >> (10 + step(m) * l)) & msk) << (12 + step(m) * l));
    end
    return pa;
  endfunction

  // Builds a chain from the root down to a leaf at level 'leaf'.
  task automatic build(input logic [3:0] m, input logic [63:0] va, input int leaf,
                       input logic [63:0] leaf_pte);
    logic [63:0] tbl = {20'd0, ROOT} << 12;
    mem.delete();
    for (int l = nlev(m) - 1; l >= leaf; l--) begin
      logic [63:0] ea = tbl + (vpn(m, va, l) << ((m == 4'd1) ? 2 : 3));
      ent_at[l] = ea;
      if (l == leaf) mem[ea] = wrap(m, leaf_pte);
      else begin
        logic [63:0] nxt = 64'h200 + 64'(l);
        mem[ea] = wrap(m, (nxt << 10) | 64'h1);
        tbl = nxt << 12;
      end
    end
  endtask

  // Memory model: ready pattern and 1-2 cycle read latency.
  initial begin
    bit          hs = 1'b0;
    bit          pend = 1'b0;
    logic [63:0] hs_addr = 64'd0;
    logic [63:0] p_addr = 64'd0;
    int          dly = 0;
    int          cyc = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 64'd0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs) begin pend = 1'b1; p_addr = hs_addr; dly = cyc % 2; end
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(p_addr) ? mem[p_addr] : 64'd0;
          pend = 1'b0;
        end else dly--;
      end
      cyc++;
      mem_req_ready = (cyc % 3) != 0;
      hs = mem_req_valid && mem_req_ready;
      hs_addr = mem_addr;
      if (hs) rd_cnt++;
    end
  end

  task automatic xlate(input logic [63:0] va, input bit en, input logic [3:0] m,
                       input logic [63:0] e_pa, input bit e_flt, input int e_rd,
                       input string req);
    int lat = 1;
    @(negedge clk);
    xlat_en = en; ctl_mode = m; ctl_root_ppn = ROOT;
    req_vaddr = va; req_valid = 1'b1; rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && lat < 300) begin @(negedge clk); lat++; end
    chk(resp_valid == 1'b1, req, "response seen", 64'(resp_valid), 64'd1);
    chk(resp_fault == e_flt, req, "fault", 64'(resp_fault), 64'(e_flt));
    chk(resp_paddr == e_pa, req, "paddr", resp_paddr, e_pa);
    chk(rd_cnt == e_rd, "R11", "read count", 64'(rd_cnt), 64'(e_rd));
    if (e_rd == 0) chk(lat == 1, req, "one-cycle latency", 64'(lat), 64'd1);
    @(negedge clk);
    chk(!resp_valid && req_ready, "R10", "pulse then ready",
        64'({resp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    logic [3:0]  modes [3] = '{4'd1, 4'd8, 4'd9};
    logic [63:0] vas [2] = '{64'h0000_7A5C_3E91_2ABC, 64'h0000_3FFF_FFFF_F123};
    logic [3:0]  flg [3] = '{4'h3, 4'h9, 4'hF};
    logic [63:0] ppn [3] = '{64'h2A5A5, 64'hABCDEF01234, 64'h5A5A5A5A5A};
    #1;
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R10", "reset ready known", 64'(req_ready), 64'd1);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0, "R10", "reset resp", 64'(resp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R9", "reset mem req", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    // R2 R4 R6 R8: sweep format x leaf level x address x leaf flags
    for (int mi = 0; mi < 3; mi++) begin
      logic [3:0] m = modes[mi];
      int vbits = (m == 4'd1) ? 32 : (m == 4'd8) ? 39 : 48;
      for (int lf = 0; lf < nlev(m); lf++)
        for (int vi = 0; vi < 2; vi++)
          for (int fi = 0; fi < 3; fi++) begin
            logic [63:0] va  = vas[vi] & ((64'd1 << vbits) - 64'd1);
            logic [63:0] pte = (ppn[mi] << 10) | 64'(flg[fi]);
            build(m, va, lf, pte);
            xlate(va, 1'b1, m, exp_pa(m, va, pte, lf), 1'b0, nlev(m) - lf, "R6");
          end
    end

    // R3 invalid entry at each level, R5 non-leaf at level 0
    for (int mi = 0; mi < 3; mi++) begin
      logic [3:0]  m = modes[mi];
      logic [63:0] va = vas[0] & 64'hFFFF_FFFF;
      for (int k = 0; k < nlev(m); k++) begin
        build(m, va, 0, (ppn[mi] << 10) | 64'h3);
        mem[ent_at[k]] = wrap(m, (64'h333 << 10) | 64'hE);
        xlate(va, 1'b1, m, 64'd0, 1'b1, nlev(m) - k, "R3");
      end
      build(m, va, 0, (ppn[mi] << 10) | 64'h3);
      mem[ent_at[nlev(m) - 1]] = wrap(m, (64'h200 << 10) | 64'h5);
      xlate(va, 1'b1, m, 64'd0, 1'b1, 1, "R3");
      build(m, va, 0, (ppn[mi] << 10) | 64'h1);
      xlate(va, 1'b1, m, 64'd0, 1'b1, nlev(m), "R5");
    end

    // R8: upper half carries a leaf, lower half invalid -> fault
    build(4'd1, 64'h1234_5678, 1, 64'd0);
    mem[ent_at[1]] = {32'h0000_000F, 32'h0};
    xlate(64'h1234_5678, 1'b1, 4'd1, 64'd0, 1'b1, 1, "R8");

    // R1 unsupported codes
    xlate(64'h1000, 1'b1, 4'd5, 64'd0, 1'b1, 0, "R1");
    xlate(64'h1000, 1'b1, 4'd15, 64'd0, 1'b1, 0, "R1");
    // R7 bypass paths
    xlate(64'hFEDC_BA98_7654_3210, 1'b0, 4'd9, 64'hFEDC_BA98_7654_3210, 1'b0, 0, "R7");
    xlate(64'h0123_4567_89AB_CDEF, 1'b1, 4'd0, 64'h0123_4567_89AB_CDEF, 1'b0, 0, "R7");
    xlate(64'h0000_0000_0000_0ABC, 1'b0, 4'd1, 64'h0000_0000_0000_0ABC, 1'b0, 0, "R7");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule